// File: doc/BRIEF.md
# Phase-Aligned Reset Release for Ratioed Clocks

This block produces one active-low reset for logic spread over two clock domains that share a phase: a slow clock and a fast clock running an integer number of times faster. Reset is applied at once, without any clock. Removal is taken through a short synchronizer on the fast clock. The output is then released only on the last fast edge before a slow rising edge. As a result, the first rising edge in either domain that sees reset gone is the same instant.

The clock generator supplies a one-fast-cycle phase strobe that marks the fast edge aligned with the slow rising edge. A small counter follows the position of each fast edge within the slow period and realigns on every strobe. The clock ratio is a static input. It is clamped into the supported range.

Top module: `rst_align_release`

## Requirements
- R1: While `rst_req_n` is low, `rst_out_n` is low, and it goes low as soon as `rst_req_n` falls, without waiting for a clock edge.
- R2: The effective ratio N is `ratio` clamped to the range 2 to MAX_RATIO. A value of 0 or 1 behaves as 2, and a value above MAX_RATIO behaves as MAX_RATIO.
- R3: After `rst_req_n` rises, at least three rising edges of `clk_fast` pass before `rst_out_n` can be high: two synchronizer stages and then the launch stage.
- R4: Fast edges are numbered 0 to N-1 within the slow period. Edge 0 is the edge at which `phase_strobe` is sampled high. `rst_out_n` rises only just after a fast edge numbered N-1, and it does so at the first such edge allowed by R3 and R7. The first fast edge and the first slow edge that sample it released are therefore both edge 0.
- R5: Once high, `rst_out_n` stays high until `rst_req_n` falls again, whatever `phase_strobe` does.
- R6: A sampled strobe always redefines the current edge as edge 0, even when it falls outside the previous numbering.
- R7: After reset, no release is launched before a strobe has been sampled. The launch edge comes strictly after that strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; also clocks the synchronizer and launch flop |
| phase_strobe | input | 1 | High for one fast cycle; sampled high at the fast edge aligned with the slow rising edge |
| rst_req_n | input | 1 | Raw asynchronous reset request, active low |
| ratio | input | $clog2(MAX_RATIO+1) | Static fast-to-slow frequency ratio |
| rst_out_n | output | 1 | Reset for both domains, active low |

## Verification
Releases are tried at random fast-clock phases and ratios of 2, 3, 4 and 8. These runs separate a correct edge-N-1 launch from a launch on edge 0 or on an early edge. Ratio values 0, 1 and 15 show whether clamping takes effect. A strobe that jumps to a new phase while reset is held shows whether the counter realigns or keeps its old count. A strobe held off after release shows that no launch happens before alignment. Repeated assertions from the released state check the clockless assertion and the stickiness of the output.

// File: rtl/rar_pkg.sv
package rar_pkg;

  // Clamp a requested ratio into the supported range 2..maxr.
  function automatic int unsigned clamp_ratio(input int unsigned req,
                                              input int unsigned maxr);
    if (req < 2) return 2;
    if (req > maxr) return maxr;
    return req;
  endfunction

  // Index of the fast edge after the current one, within a period of n.
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Counter value one edge before the launch edge (index n-1).
  function automatic int unsigned pre_launch_index(input int unsigned n);
    return n - 2;
  endfunction

endpackage

// File: rtl/rar_sync.sv
module rar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic released
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign released = chain_q[STAGES-1];
endmodule

// File: rtl/rar_phase_ctr.sv
module rar_phase_ctr
  import rar_pkg::*;
#(
  parameter int unsigned MAX_RATIO = 8,
  localparam int unsigned CW = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_strobe,
  input  logic [CW-1:0] ratio,
  output logic          aligned,
  output logic          launch_slot
);
  logic [CW-1:0] eff_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          aligned_q;

  assign eff_n = CW'(clamp_ratio(32'(ratio), MAX_RATIO));

  always_comb begin
    if (phase_strobe) cnt_d = '0;
    else              cnt_d = CW'(next_index(32'(cnt_q), 32'(eff_n)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      aligned_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (phase_strobe) aligned_q <= 1'b1;
    end
  end

  assign aligned     = aligned_q;
  assign launch_slot = aligned_q && !phase_strobe &&
                       (32'(cnt_q) == pre_launch_index(32'(eff_n)));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_n >= CW'(2)) && (32'(eff_n) <= MAX_RATIO) && (cnt_q < eff_n)); // R2

  AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    phase_strobe |=> (cnt_q == '0) && aligned_q); // R6

  AST_SLOT_PRECEDES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    launch_slot |=> (cnt_q == eff_n - CW'(1))); // R4
endmodule

// File: rtl/rar_launch.sv
module rar_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_synced,
  input  logic launch_slot,
  output logic out_n
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        out_q <= 1'b0;
    else if (req_synced && launch_slot) out_q <= 1'b1;
  end

  assign out_n = out_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |=> out_q); // R5
endmodule

// File: rtl/rst_align_release.sv
module rst_align_release #(
  parameter int unsigned MAX_RATIO   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk_fast,
  input  logic          phase_strobe,
  input  logic          rst_req_n,
  input  logic [CW-1:0] ratio,
  output logic          rst_out_n
);
  logic req_synced;
  logic aligned;
  logic launch_slot;

  rar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_fast),
    .rst_n    (rst_req_n),
    .released (req_synced)
  );

  rar_phase_ctr #(.MAX_RATIO(MAX_RATIO)) u_phase (
    .clk          (clk_fast),
    .rst_n        (rst_req_n),
    .phase_strobe (phase_strobe),
    .ratio        (ratio),
    .aligned      (aligned),
    .launch_slot  (launch_slot)
  );

  rar_launch u_launch (
    .clk         (clk_fast),
    .rst_n       (rst_req_n),
    .req_synced  (req_synced),
    .launch_slot (launch_slot),
    .out_n       (rst_out_n)
  );

  AST_LOW_IN_RESET: assert property (@(posedge clk_fast)
    !rst_req_n |-> !rst_out_n); // R1

  AST_RISE_ON_SLOT: assert property (@(posedge clk_fast) disable iff (!rst_req_n)
    $rose(rst_out_n) |-> $past(launch_slot)); // R4

  AST_RISE_AFTER_SYNC: assert property (@(posedge clk_fast) disable iff (!rst_req_n)
    $rose(rst_out_n) |-> $past(req_synced)); // R3

  AST_RISE_ALIGNED: assert property (@(posedge clk_fast) disable iff (!rst_req_n)
    $rose(rst_out_n) |-> $past(aligned)); // R7
endmodule

// File: tb/rst_align_release_test.sv
module rst_align_release_test;
  localparam int unsigned MAXR = 8;
  localparam int unsigned CW   = $clog2(MAXR + 1);

  logic          clk = 1'b0;
  logic          phase_strobe = 1'b0;
  logic          rst_req_n = 1'b0;
  logic [CW-1:0] ratio = CW'(2);
  logic          rst_out_n;

  int unsigned checks = 0, errors = 0;
  int unsigned n = 2, bidx = 0, edge_idx = 0;
  int          edges = 0;
  bit          strobe_en = 1'b1, last_strobe = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  rst_align_release #(.MAX_RATIO(MAXR)) uut (
    .clk_fast(clk), .phase_strobe(phase_strobe), .rst_req_n(rst_req_n),
    .ratio(ratio), .rst_out_n(rst_out_n)
  );

  function automatic int unsigned exp_ratio(input int unsigned r);
    if (r <= 1) return 2;
    return (r > MAXR) ? MAXR : r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    last_strobe = phase_strobe;
    edge_idx = bidx;
    bidx = (bidx + 1) % n;
    edges++;
    @(negedge clk);
    phase_strobe = strobe_en && (bidx == 0);
  endtask

  task automatic run_trial(input int unsigned rin, input bit jump,
                           input bit hold, input string tag);
    int rel, e_exp, e_rise, drops;
    bit seen;
    rst_req_n = 1'b0;
    #1;
    check(rst_out_n == 1'b0, "R1", rst_out_n, 0);
    ratio = CW'(rin);
    n = exp_ratio(rin);
    bidx = jump ? ($urandom % n) : (bidx % n);
    phase_strobe = strobe_en && (bidx == 0);
    repeat (2 + $urandom % 4) step();
    check(rst_out_n == 1'b0, "R1", rst_out_n, 0);
    strobe_en = !hold;
    phase_strobe = strobe_en && (bidx == 0);
    rst_req_n = 1'b1;
    rel = edges; seen = 0; e_exp = -1; e_rise = -1;
    if (hold) begin
      repeat (30) step();
      check(rst_out_n == 1'b0, "R7", rst_out_n, 0);
      strobe_en = 1'b1;
      phase_strobe = (bidx == 0);
    end
    for (int k = 0; k < int'(4 * n + 12); k++) begin
      step();
      if (e_exp < 0 && edge_idx == n - 1 && edges >= rel + 3 && seen) e_exp = edges;
      if (last_strobe) seen = 1;
      if (e_rise < 0 && rst_out_n) e_rise = edges;
    end
    check(e_rise == e_exp, {tag, " R4"}, e_rise - rel, e_exp - rel);
    check(e_rise >= rel + 3, "R3", e_rise - rel, 3);
    drops = 0;
    for (int k = 0; k < 10; k++) begin
      phase_strobe = ($urandom % 2) == 1;
      @(posedge clk); @(negedge clk);
      edges++;
      if (!rst_out_n) drops++;
    end
    check(drops == 0, "R5", drops, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check(rst_out_n == 1'b0, "R1 reset state", rst_out_n, 0);
    run_trial(2, 0, 0, "N2");
    run_trial(4, 0, 0, "N4");
    run_trial(0, 1, 0, "R2 low clamp");
    run_trial(1, 1, 0, "R2 low clamp");
    run_trial(15, 1, 0, "R2 high clamp");
    run_trial(4, 0, 1, "R7 hold");
    run_trial(4, 1, 0, "R6 jump");
    run_trial(2, 1, 0, "R6 jump");
    for (int t = 0; t < 24; t++) begin
      int unsigned pick;
      pick = $urandom % 4;
      run_trial(pick == 0 ? 2 : pick == 1 ? 3 : pick == 2 ? 4 : 8,
                ($urandom % 2) == 1, ($urandom % 6) == 0, "R6 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule